// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter clocked by the system clock. Software picks one of four power-of-two interval lengths with a 2-bit select. When an interval runs out without a restart, the block first warns: it sets a sticky interrupt flag, and drives the interrupt line if interrupts are enabled. A fixed grace window then opens. If software restarts the watchdog inside that window, nothing further happens and a fresh interval begins. If the window runs out, the block emits a one-cycle reset request and begins a new interval from zero.

The select is sampled only when a new interval begins, so a change never shortens or stretches the interval already running. The interrupt flag is independent of the reset path. It stays set until software clears it.

Top module: `wdt_two_stage`

## Requirements
- R1: With defaults, select 00, 01, 10 and 11 give intervals of 2^15, 2^18, 2^21 and 2^24 clock cycles. In general the interval is 2^(BASE_EXP + STEP_EXP*sel). If the last restart takes effect at clock edge E, the interval ends at edge E+T.
- R2: At the edge where the interval ends, `irq_flag_o` goes to 1. `irq_o` equals `irq_flag_o & irq_en_i` at all times.
- R3: If no restart arrives, `rst_req_o` is 1 in the cycle after edge E+T+GRACE and 0 before it. The default GRACE is 512.
- R4: A restart during the grace window prevents the reset request, and a full new interval starts from the restart edge.
- R5: A restart at any time clears the counter, so the next timeout comes T cycles after the restart edge.
- R6: `irq_flag_o` stays at 1 until `irq_clr_i` is sampled high. If a clear and a timeout fall in the same cycle, the flag ends set.
- R7: `period_sel_i` is sampled only on a restart and at the edge that issues a reset request. A change in the middle of an interval does not alter that interval. After reset the sampled select is 00.
- R8: `rst_req_o` lasts exactly one cycle. The counter is zero at that edge, so the next timeout follows T cycles later.
- R9: While `en_i` is 0, the counter is held at zero and no timeout or reset request occurs. Counting resumes from zero once `en_i` returns to 1.
- R10: While `rst_ni` is low, `irq_flag_o`, `irq_o` and `rst_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables counting |
| period_sel_i | input | 2 | Interval select, sampled at interval start |
| irq_en_i | input | 1 | Gates the interrupt output |
| restart_i | input | 1 | Restart strobe |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt, flag gated by the enable |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with BASE_EXP=4, STEP_EXP=3 and GRACE=8. This gives intervals of 16, 128, 1024 and 8192 cycles. With these values all four select codes can be run to the exact cycle of their timeout and of the following reset request. The short grace window also brings within reach the cases where a restart lands inside the window, where a select change spans a reset request, and where a clear coincides with a timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {PH_COUNT = 1'b0, PH_GRACE = 1'b1} wdt_phase_e;
endpackage

// File: rtl/wdt_period_dec.sv
module wdt_period_dec #(
  parameter int BASE_EXP = 15,
  parameter int STEP_EXP = 3,
  parameter int CW       = BASE_EXP + 3 * STEP_EXP
) (
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] term_o
);
  logic [CW-1:0] term_tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_term
    localparam int EXP = BASE_EXP + STEP_EXP * g;
    assign term_tbl[g] = CW'((64'd1 << EXP) - 64'd1);
  end

  assign term_o = term_tbl[sel_i];
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int STEP_EXP = 3,
  parameter int GRACE    = 512,
  parameter int CW       = BASE_EXP + 3 * STEP_EXP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [1:0] period_sel_i,
  output logic       timeout_o,
  output logic       in_grace_o,
  output logic       rst_req_o
);
  localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE - 1);

  wdt_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] term;
  logic          grace_end;

  wdt_period_dec #(
    .BASE_EXP(BASE_EXP),
    .STEP_EXP(STEP_EXP),
    .CW      (CW)
  ) u_dec (
    .sel_i (sel_q),
    .term_o(term)
  );

  // timeout and grace-end are only live when nothing overrides the count
  assign timeout_o  = en_i && !restart_i && (phase_q == PH_COUNT) && (cnt_q == term);
  assign grace_end  = en_i && !restart_i && (phase_q == PH_GRACE) && (cnt_q == GRACE_LAST);
  assign in_grace_o = (phase_q == PH_GRACE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_COUNT;
      cnt_q     <= '0;
      sel_q     <= 2'b00;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= grace_end;
      if (restart_i) begin
        phase_q <= PH_COUNT;
        cnt_q   <= '0;
        sel_q   <= period_sel_i;
      end else if (!en_i) begin
        phase_q <= PH_COUNT;
        cnt_q   <= '0;
      end else if (timeout_o) begin
        phase_q <= PH_GRACE;
        cnt_q   <= '0;
      end else if (grace_end) begin
        phase_q <= PH_COUNT;
        cnt_q   <= '0;
        sel_q   <= period_sel_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_irq_flag.sv
module wdt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int BASE_EXP = 15,
  parameter int STEP_EXP = 3,
  parameter int GRACE    = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] period_sel_i,
  input  logic       irq_en_i,
  input  logic       restart_i,
  input  logic       irq_clr_i,
  output logic       irq_flag_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  localparam int CW = BASE_EXP + 3 * STEP_EXP;

  logic timeout;
  logic in_grace;

  wdt_core #(
    .BASE_EXP(BASE_EXP),
    .STEP_EXP(STEP_EXP),
    .GRACE   (GRACE),
    .CW      (CW)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .restart_i   (restart_i),
    .period_sel_i(period_sel_i),
    .timeout_o   (timeout),
    .in_grace_o  (in_grace),
    .rst_req_o   (rst_req_o)
  );

  wdt_irq_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (timeout),
    .clr_i   (irq_clr_i),
    .irq_en_i(irq_en_i),
    .flag_o  (irq_flag_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic restart_i,
  input logic irq_clr_i,
  input logic irq_en_i,
  input logic irq_flag_o,
  input logic irq_o,
  input logic rst_req_o,
  input logic in_grace
);
  assert_irq_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_flag_o && irq_en_i));

  assert_grace_has_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_grace) |-> irq_flag_o);

  assert_req_from_grace_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(in_grace));

  assert_restart_cancels_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!rst_req_o && !in_grace));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_flag_o) |-> $past(irq_clr_i));

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .restart_i (restart_i),
  .irq_clr_i (irq_clr_i),
  .irq_en_i  (irq_en_i),
  .irq_flag_o(irq_flag_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .in_grace  (in_grace)
);

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  localparam int BASE  = 4;
  localparam int STEP  = 3;
  localparam int GR    = 8;
  localparam int NVEC  = 6;
  // {sel[1:0], irq_en}
  localparam logic [2:0] STIM [NVEC] = '{3'b000, 3'b011, 3'b100, 3'b111, 3'b001, 3'b110};
  localparam int EXP_T [NVEC] = '{16, 128, 1024, 8192, 16, 8192};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [1:0] sel = 2'b00;
  logic irq_en = 1'b0;
  logic restart = 1'b0;
  logic clr = 1'b0;
  logic flag, irq, req;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_two_stage #(.BASE_EXP(BASE), .STEP_EXP(STEP), .GRACE(GR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_sel_i(sel),
    .irq_en_i(irq_en), .restart_i(restart), .irq_clr_i(clr),
    .irq_flag_o(flag), .irq_o(irq), .rst_req_o(req)
  );

  task automatic chk(input string req_id, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_id, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // restart edge is E0; returns at the negedge after it (k = 0)
  task automatic do_restart(input logic [1:0] s);
    sel = s;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    wait_n(3);
    chk("R10 flag", flag, 0);
    chk("R10 irq", irq, 0);
    chk("R10 req", req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1, R2, R3, R8
    for (int v = 0; v < NVEC; v++) begin
      irq_en = STIM[v][0];
      do_restart(STIM[v][2:1]);
      wait_n(EXP_T[v] - 1);
      chk("R1 before timeout", flag, 0);
      wait_n(1);
      chk("R1 at timeout", flag, 1);
      chk("R2 irq gate", irq, int'(STIM[v][0]));
      wait_n(GR - 1);
      chk("R3 before req", req, 0);
      wait_n(1);
      chk("R3 req", req, 1);
      wait_n(1);
      chk("R8 one cycle", req, 0);
      do_clear();
    end

    // R8: after the pulse a full new interval (sel 00 -> 16)
    irq_en = 1'b1;
    do_restart(2'b00);
    wait_n(16 + GR);
    chk("R8 req", req, 1);
    do_clear();
    wait_n(16 - 2);
    chk("R8 next interval early", flag, 0);
    wait_n(1);
    chk("R8 next timeout", flag, 1);
    do_clear();

    // R4: restart inside the window
    do_restart(2'b00);
    wait_n(16 + 3);
    chk("R4 in window", flag, 1);
    do_clear();
    do_restart(2'b00);
    wait_n(GR);
    chk("R4 no req", req, 0);
    wait_n(15 - GR);
    chk("R4 new interval", flag, 0);
    wait_n(1);
    chk("R4 new timeout", flag, 1);
    do_clear();

    // R5: restart mid-interval pushes timeout out
    do_restart(2'b00);
    wait_n(10);
    do_restart(2'b00);
    wait_n(15);
    chk("R5 pushed", flag, 0);
    wait_n(1);
    chk("R5 timeout", flag, 1);

    // R6: flag holds through the window and the request until cleared
    wait_n(GR + 5);
    chk("R6 sticky", flag, 1);
    do_clear();
    chk("R6 cleared", flag, 0);

    // R6: clear coincident with timeout, set wins
    do_restart(2'b00);
    wait_n(15);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R6 set wins", flag, 1);
    do_clear();

    // R7: select change mid-interval only after the request
    do_restart(2'b00);
    wait_n(2);
    sel = 2'b01;
    wait_n(14);
    chk("R7 old period", flag, 1);
    do_clear();
    wait_n(GR - 1);
    chk("R7 req", req, 1);
    wait_n(127);
    chk("R7 new period early", flag, 0);
    wait_n(1);
    chk("R7 new period", flag, 1);
    do_clear();

    // R9: disabled holds at zero
    en = 1'b0;
    do_restart(2'b00);
    wait_n(40);
    chk("R9 no timeout", flag, 0);
    chk("R9 no req", req, 0);
    en = 1'b1;
    wait_n(15);
    chk("R9 resume early", flag, 0);
    wait_n(1);
    chk("R9 resume", flag, 1);
    chk("R2 irq on", irq, 1);
    irq_en = 1'b0;
    #1;
    chk("R2 irq off", irq, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule